// File: doc/BRIEF.md
# Sequential Divider with Quotient Extension Register

This unit performs integer division for a 32-bit core. It works over many cycles and owns an auxiliary 32-bit register named MQ. It offers two forms of divide.

- **Long divide:** the dividend is 64 bits, built from the `ra` operand as the upper word and the current MQ contents as the lower word.
- **Short divide:** the dividend is the signed 32-bit `ra` operand alone.

In both forms `rb` is the divisor. The quotient is returned on `quotient`, and the remainder replaces the contents of MQ. A restoring shift-subtract loop works on magnitudes and produces one quotient bit per cycle. Signs are then corrected, so the quotient truncates toward zero and the remainder takes the sign of the dividend.

Two flags modify a divide. With `oe` set, the overflow flag is updated and a sticky summary-overflow flag is accumulated. With `rc` set, a four-bit condition field is recorded from the quotient. MQ can also be written directly through its own port while the unit is idle. Software uses this port to supply the low dividend word before a long divide.

Top module: `mq_divider`

## Requirements
- R1: With `op_long`=1, the dividend is the signed 64-bit value {`ra`,MQ} and the divisor is signed `rb`. `quotient` receives the quotient truncated toward zero, as a 32-bit two's-complement value.
- R2: With `op_long`=0, `quotient` receives signed `ra` divided by signed `rb`, truncated toward zero.
- R3: After a divide with no overflow, `mq` holds the remainder. The remainder has the sign of the dividend, or is zero, and its magnitude is below the divisor's magnitude.
- R4: A start accepted at a clock edge raises `busy` for N+1 cycles, with N=64 for long and N=32 for short. As `busy` falls, `done` is high for exactly one cycle, and the results are valid from that same cycle.
- R5: A `start` seen while `busy` is high is ignored. The running operation's results and timing are unchanged.
- R6: With `oe`=1, `ov` is set when the divisor is zero or the quotient does not fit in 32 signed bits, and is cleared otherwise. `so` is ORed with the new `ov` value and is never cleared except by reset. With `oe`=0, neither `ov` nor `so` changes.
- R7: With `rc`=1 and no overflow, `cr` is set to {LT,GT,EQ,SO}, taken from bit 3 down to bit 0. LT, GT and EQ compare the signed quotient with zero, and SO is the updated `so`. With `rc`=0, `cr` is unchanged.
- R8: `mq_we` loads `mq_wdata` into MQ when the unit is idle and `start` is low. The write is ignored while the unit is busy or when `start` is high in the same cycle.
- R9: After reset, `busy`, `done`, `quotient`, `mq`, `ov`, `so` and `cr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divide (accepted when idle) |
| op_long | input | 1 | 1: 64-bit {ra,MQ} dividend; 0: 32-bit signed ra |
| ra | input | 32 | Dividend operand (upper word for long divide) |
| rb | input | 32 | Signed divisor |
| oe | input | 1 | Update overflow flags |
| rc | input | 1 | Record condition field |
| mq_we | input | 1 | Direct MQ write strobe |
| mq_wdata | input | 32 | Direct MQ write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the last divide |
| mq | output | 32 | Current MQ contents |
| ov | output | 1 | Overflow flag |
| so | output | 1 | Sticky summary overflow |
| cr | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
A wrong iteration count, or a stale loop counter, moves the edge where `busy` falls and `done` pulses. The per-cycle comparison against the reference timeline therefore exposes it within one cycle of the expected completion. A fault in the partial remainder or in the sign fix-up stays hidden until `done`. It then shows in both `quotient` and `mq` at once. The vector set mixes every sign combination and both dividend widths, so a fault of either kind is caught on the first affected divide. A corrupted MQ, or a write port that leaks while busy, shows on `mq` in the very next cycle, because MQ must stay stable for the whole operation.

// File: rtl/mq_divider.sv
module mq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_long,
  input  logic [W-1:0] ra,
  input  logic [W-1:0] rb,
  input  logic         oe,
  input  logic         rc,
  input  logic         mq_we,
  input  logic [W-1:0] mq_wdata,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] mq,
  output logic         ov,
  output logic         so,
  output logic [3:0]   cr
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] N_LONG  = CW'(DW);
  localparam logic [CW-1:0] N_SHORT = CW'(W);
  localparam logic [DW-1:0] QLIM = DW'(1) << (W - 1);

  logic          run, fin;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dq;
  logic [W-1:0]  rem, dvs;
  logic          neg_q, neg_r, oe_r, rc_r;

  wire           idle  = !run && !fin;
  wire           go    = start && idle;
  wire [DW-1:0]  dd64  = {ra, mq};
  wire           neg_d = op_long ? dd64[DW-1] : ra[W-1];
  wire [DW-1:0]  mag64 = dd64[DW-1] ? -dd64 : dd64;
  wire [W-1:0]   mag32 = ra[W-1] ? -ra : ra;
  wire [DW-1:0]  mag_d = op_long ? mag64 : {mag32, {W{1'b0}}};

  wire [W:0]     rs    = {rem, dq[DW-1]};
  wire [W:0]     diff  = rs - {1'b0, dvs};
  wire           ge    = !diff[W];

  wire           fits  = neg_q ? (dq <= QLIM) : (dq < QLIM);
  wire           ovf   = (dvs == '0) || !fits;
  wire [W-1:0]   q_res = neg_q ? -dq[W-1:0] : dq[W-1:0];
  wire [W-1:0]   r_res = neg_r ? -rem : rem;
  wire           so_nx = so | (oe_r & ovf);

  assign busy = run | fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      fin <= 1'b0;
      cnt <= '0;
      dq <= '0;
      rem <= '0;
      dvs <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
      oe_r <= 1'b0;
      rc_r <= 1'b0;
      done <= 1'b0;
      quotient <= '0;
      mq <= '0;
      ov <= 1'b0;
      so <= 1'b0;
      cr <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run <= 1'b1;
        cnt <= op_long ? N_LONG : N_SHORT;
        dq <= mag_d;
        rem <= '0;
        dvs <= rb[W-1] ? -rb : rb;
        neg_q <= neg_d ^ rb[W-1];
        neg_r <= neg_d;
        oe_r <= oe;
        rc_r <= rc;
      end else if (idle && mq_we) begin
        mq <= mq_wdata;
      end
      if (run) begin
        rem <= ge ? diff[W-1:0] : rs[W-1:0];
        dq <= {dq[DW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
      if (fin) begin
        fin <= 1'b0;
        done <= 1'b1;
        quotient <= q_res;
        mq <= r_res;
        if (oe_r) begin
          ov <= ovf;
          so <= so_nx;
        end
        if (rc_r && !ovf)
          cr <= {q_res[W-1], !q_res[W-1] && (q_res != '0), q_res == '0, so_nx};
      end
    end
  end
endmodule

// File: rtl/mq_divider_checks.sv
module mq_divider_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] mq,
  input logic         ov,
  input logic         so,
  input logic [3:0]   cr
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_mq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || $stable(mq)));
  assert_so_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    so |=> so);
  assert_ov_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ov) |-> done);
  assert_cr_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cr) |-> done);
endmodule

bind mq_divider mq_divider_checks #(.W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mq(mq), .ov(ov), .so(so), .cr(cr)
);

// File: tb/tb_mq_divider.sv
module tb_mq_divider;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, op_long = 0, oe = 0, rc = 0, mq_we = 0;
  logic [31:0] ra = 0, rb = 0, mq_wdata = 0;
  logic        busy, done, ov, so;
  logic [31:0] quotient, mq;
  logic [3:0]  cr;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_q, m_mq;
  logic        m_ov, m_so;
  logic [3:0]  m_cr;

  mq_divider dut (.*);

  always #5 clk = ~clk;

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mq_load(input logic [31:0] v);
    @(negedge clk); mq_we = 1; mq_wdata = v;
    @(negedge clk); mq_we = 0;
    check(mq == v, "R8 idle load", mq, v);
    m_mq = v;
  endtask

  task automatic run_div(input bit lng, input logic [31:0] a, input logic [31:0] b,
                         input bit e, input bit r, input bit disturb);
    logic [63:0] dd, md, qm, rm;
    logic [31:0] mv, eq, er;
    bit nd, nq, ovf;
    int n;
    dd = lng ? {a, m_mq} : {{32{a[31]}}, a};
    nd = dd[63];
    md = nd ? -dd : dd;
    mv = b[31] ? -b : b;
    nq = nd ^ b[31];
    ovf = (b == 0);
    qm = 0; rm = 0;
    if (!ovf) begin
      qm = md / {32'd0, mv};
      rm = md % {32'd0, mv};
      ovf = nq ? (qm > 64'h8000_0000) : (qm >= 64'h8000_0000);
    end
    eq = nq ? -qm[31:0] : qm[31:0];
    er = nd ? -rm[31:0] : rm[31:0];
    n = lng ? 64 : 32;
    @(negedge clk);
    start = 1; op_long = lng; ra = a; rb = b; oe = e; rc = r;
    @(negedge clk);
    start = 0; ra = 32'h1234_5678; rb = 32'h3; op_long = ~lng;
    for (int j = 0; j <= n; j++) begin
      check(busy && !done, "R4 busy window", {busy, done}, 2'b10);
      if (disturb && j == 5) begin
        start = 1; mq_we = 1; mq_wdata = ~m_mq;
      end
      @(negedge clk);
      if (disturb && j == 5) begin
        start = 0; mq_we = 0;
        check(mq == m_mq, "R8 write while busy", mq, m_mq);
      end
    end
    check(done && !busy, "R4 done pulse", {busy, done}, 2'b01);
    if (e) begin
      m_ov = ovf;
      m_so = m_so | ovf;
    end
    if (!ovf) begin
      m_q = eq; m_mq = er;
      if (r) m_cr = {eq[31], !eq[31] && eq != 0, eq == 0, m_so};
      check(quotient == m_q, lng ? "R1 long quotient" : "R2 short quotient", quotient, m_q);
      check(mq == m_mq, "R3 remainder", mq, m_mq);
      check(cr == m_cr, "R7 condition field", cr, m_cr);
    end
    check(ov == m_ov, "R6 ov", ov, m_ov);
    check(so == m_so, "R6 so", so, m_so);
    if (!ovf) check(mq == m_mq && quotient == m_q, "R5 result intact", mq, m_mq);
    @(negedge clk);
    check(!done && !busy, "R4 done one cycle", {busy, done}, 2'b00);
    if (ovf) m_mq = mq;
  endtask

  initial begin
    m_q = 0; m_mq = 0; m_ov = 0; m_so = 0; m_cr = 0;
    repeat (3) @(negedge clk);
    check({busy, done, quotient, mq, ov, so, cr} == '0, "R9 reset", quotient, 0);
    rst_n = 1;
    // R8: write with start high ignored, start wins
    @(negedge clk); mq_we = 1; mq_wdata = 32'hdead_beef; start = 1; ra = 100; rb = 7; op_long = 0;
    @(negedge clk); mq_we = 0; start = 0;
    check(mq == 0, "R8 write with start", mq, 0);
    while (busy) @(negedge clk);
    check(quotient == 14 && mq == 2, "R2 first", quotient, 14);
    m_q = 14; m_mq = 2;
    run_div(0, 32'd100, 32'd7, 0, 1, 0);
    run_div(0, -32'd100, 32'd7, 1, 1, 0);
    run_div(0, 32'd100, -32'd7, 0, 1, 1);
    run_div(0, -32'd100, -32'd7, 1, 0, 0);
    run_div(0, 32'd42, 32'd6, 1, 1, 0);
    run_div(0, 32'h8000_0000, 32'd1, 1, 1, 0);
    mq_load(32'h0000_0005);
    run_div(1, 32'd3, 32'd16, 1, 1, 0);
    mq_load(32'h9abc_def0);
    run_div(1, 32'hffff_fff0, 32'd1000, 0, 1, 1);
    mq_load(32'h1111_2222);
    run_div(1, 32'h0000_0002, -32'd77, 1, 1, 0);
    mq_load(32'h0);
    run_div(1, 32'h0000_0001, 32'd1, 1, 1, 0);
    run_div(0, 32'd9, 32'd0, 0, 1, 0);
    run_div(0, 32'd9, 32'd0, 1, 1, 0);
    run_div(0, 32'h8000_0000, 32'hffff_ffff, 1, 0, 0);
    run_div(0, 32'd50, 32'd5, 1, 1, 0);
    run_div(0, -32'd51, 32'd5, 0, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule